// File: doc/BRIEF.md
# Central Bus Arbiter with Hidden Arbitration and Parking

This block decides which of N bus masters may start the next transaction on a shared, multi-master parallel bus. Each master asks through its own active-low request line and is told through its own active-low grant line. The arbiter watches the two bus-activity strobes: the cycle strobe `frame_n` and the initiator-ready strobe `irdy_n`. It can therefore move the grant to the next owner while the current transaction is still running, so no bus clocks are spent on arbitration. A master that sees its grant on an idle bus may begin its transaction on the following clock.

Fairness comes from a rotating priority. The search starts at the master after the last one that actually took the bus. A granted master keeps its grant until it has used it once, and it then loses the grant as soon as anyone else asks. When nobody requests, the bus is parked according to `park_mode`: on no agent, on a fixed agent, or on the last bus owner.

Each master also has a latency-timer limit. When the grant of the current owner has been taken away and the owner has held the bus for at least its limit, the arbiter raises that master's `must_yield` line so the master can end its burst.

Top module: `central_bus_arbiter`

## Requirements
- R1: At every clock at most one bit of `gnt_n` is low.
- R2: A grant never passes directly from one agent to another. Between two different agents, `gnt_n` is all ones for at least one clock.
- R3: A new grant to a requester goes to the first requesting index found by searching upward (with wraparound) from the index after the last bus owner. The last bus owner itself is searched last.
- R4: While the granted agent keeps requesting and has not yet started a transaction on this grant, its grant is not changed, whatever the other requests are.
- R5: With `park_mode` = 0 (no parking), or with `park_mode` = 3, a clock on which no request is low is followed by a clock with `gnt_n` all ones.
- R6: With `park_mode` = 1 and no request pending, the grant settles on the agent indexed by `park_agent`. If that index is not below N, no grant is given.
- R7: With `park_mode` = 2 and no request pending, the grant settles on the last bus owner. After reset the last bus owner is taken as index N-1.
- R8: During reset `gnt_n` is all ones and `must_yield` is all zeros. The first arbitration after reset starts its search at index 0.
- R9: A transaction starts on the clock where `frame_n` goes low, provided `frame_n` and `irdy_n` were both high on the previous clock while exactly one grant was active. The owner is that granted agent, even if its grant has moved on since.
- R10: `must_yield[i]` is high exactly when agent i owns a running transaction, `gnt_n[i]` is high, and the owner has held the bus for at least `lat_limit[i*TW +: TW]` clocks. The count is zero on the clock after the start, and the line is low whenever the bus is idle.
- R11: A master that requests and starts a transaction whenever it sees its grant on an idle bus is granted and starts within a bounded number of clocks. The grant may move to the next owner while the bus is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N | Per-master request, active low |
| gnt_n | output | N | Per-master grant, active low |
| frame_n | input | 1 | Bus cycle strobe, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| park_mode | input | 2 | 0 none, 1 fixed agent, 2 last owner, 3 none |
| park_agent | input | IW | Agent index used for fixed parking |
| lat_limit | input | N*TW | Per-master latency-timer limits, master i in bits i*TW +: TW |
| must_yield | output | N | Per-master signal to end the burst |

## Verification
The bench goes after several corner cases.

- **Release of reset with every master requesting.** A wrong start index for the rotation would grant agent N-1 or 1 first instead of 0.
- **New request arriving while another master holds an unused grant.** A design that re-arbitrates every clock would move the grant before its holder could ever start, which starves masters and breaks the wait bound.
- **Grant changes while the bus is busy.** Here a missing idle clock between agents would show two agents granted back to back, and owner tracking based on the current grant instead of the grant at start would raise `must_yield` on the wrong master.
- **All requests dropping in each parking mode.** These drain periods expose a design that parks on the wrong agent or keeps a stale grant.

// File: rtl/cba_pkg.sv
package cba_pkg;

  typedef enum logic [1:0] {
    PARK_OFF   = 2'd0,
    PARK_FIXED = 2'd1,
    PARK_LAST  = 2'd2,
    PARK_RSVD  = 2'd3
  } park_e;

  // Saturating increment for a counter of up to 32 bits held in an int-sized value.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] max_v);
    return (v >= max_v) ? max_v : v + 32'd1;
  endfunction

endpackage

// File: rtl/cba_rr_select.sv
module cba_rr_select #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base_idx,
  output logic          win_v,
  output logic [IW-1:0] win_idx
);

  // Search upward from base_idx+1; base_idx itself is visited last.
  function automatic logic [IW:0] rr_choose(input logic [N-1:0] r, input logic [IW-1:0] base);
    logic [IW:0] res;
    int pos;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      pos = (int'(base) + k) % N;
      if (r[pos]) res = {1'b1, IW'(pos)};
    end
    return res;
  endfunction

  logic [IW:0] pick;

  always_comb begin
    pick    = rr_choose(req, base_idx);
    win_v   = pick[IW];
    win_idx = pick[IW-1:0];
  end

endmodule

// File: rtl/cba_bus_watch.sv
module cba_bus_watch import cba_pkg::*; #(
  parameter int N  = 4,
  parameter int TW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic [N-1:0]    gnt,
  input  logic [N*TW-1:0] lat_limit,
  output logic            bus_idle,
  output logic            start,
  output logic [IW-1:0]   start_idx,
  output logic [IW-1:0]   last_idx,
  output logic [N-1:0]    must_yield
);

  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  function automatic logic [IW-1:0] first_idx(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic [N-1:0]  cand_q;
  logic          owner_v_q;
  logic [IW-1:0] owner_q;
  logic [TW-1:0] tmr_q;
  logic [IW-1:0] last_q;

  assign bus_idle  = frame_n & irdy_n;
  assign start     = (|cand_q) & ~frame_n;
  assign start_idx = first_idx(cand_q);
  assign last_idx  = last_q;

  // Snapshot of the grant seen on an idle bus: the possible next owner.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cand_q <= '0;
    else        cand_q <= bus_idle ? gnt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_v_q <= 1'b0;
      owner_q   <= '0;
      tmr_q     <= '0;
      last_q    <= IW'(N - 1);
    end else if (start) begin
      owner_v_q <= 1'b1;
      owner_q   <= start_idx;
      tmr_q     <= '0;
      last_q    <= start_idx;
    end else if (bus_idle) begin
      owner_v_q <= 1'b0;
      tmr_q     <= '0;
    end else if (owner_v_q) begin
      tmr_q     <= TW'(sat_inc(32'(tmr_q), 32'(TMAX)));
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_yield
    assign must_yield[i] = owner_v_q && (owner_q == IW'(i)) && !gnt[i] && !bus_idle &&
                           (tmr_q >= lat_limit[i*TW +: TW]);
  end

endmodule

// File: rtl/cba_grant_fsm.sv
module cba_grant_fsm import cba_pkg::*; #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          win_v,
  input  logic [IW-1:0] win_idx,
  input  logic [1:0]    park_mode,
  input  logic [IW-1:0] park_agent,
  input  logic [IW-1:0] last_idx,
  input  logic          start,
  input  logic [IW-1:0] start_idx,
  output logic [N-1:0]  gnt,
  output logic          hold
);

  function automatic logic [IW-1:0] first_idx(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [N-1:0] to_onehot(input logic [IW-1:0] idx);
    logic [N-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (idx == IW'(i)) r[i] = 1'b1;
    return r;
  endfunction

  logic [N-1:0]  gnt_q, gnt_d;
  logic          used_q, used_d;
  logic          g_v;
  logic [IW-1:0] g_idx;
  logic          tgt_v;
  logic [IW-1:0] tgt_idx;
  park_e         pmode;

  assign pmode = park_e'(park_mode);
  assign g_v   = |gnt_q;
  assign g_idx = first_idx(gnt_q);
  assign hold  = g_v && req[g_idx] && !used_q;
  assign gnt   = gnt_q;

  always_comb begin
    tgt_v   = 1'b0;
    tgt_idx = '0;
    if (hold) begin
      tgt_v   = 1'b1;
      tgt_idx = g_idx;
    end else if (win_v) begin
      tgt_v   = 1'b1;
      tgt_idx = win_idx;
    end else begin
      case (pmode)
        PARK_FIXED: begin
          tgt_v   = int'(park_agent) < N;
          tgt_idx = park_agent;
        end
        PARK_LAST: begin
          tgt_v   = 1'b1;
          tgt_idx = last_idx;
        end
        default: tgt_v = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (!g_v)                           gnt_d = tgt_v ? to_onehot(tgt_idx) : '0;
    else if (tgt_v && tgt_idx == g_idx) gnt_d = gnt_q;
    else                                gnt_d = '0;

    if (gnt_d != gnt_q)                        used_d = 1'b0;
    else if (start && g_v && start_idx == g_idx) used_d = 1'b1;
    else                                       used_d = used_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      used_q <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      used_q <= used_d;
    end
  end

endmodule

// File: rtl/central_bus_arbiter.sv
module central_bus_arbiter import cba_pkg::*; #(
  parameter int N  = 4,
  parameter int TW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_n,
  output logic [N-1:0]    gnt_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic [1:0]      park_mode,
  input  logic [IW-1:0]   park_agent,
  input  logic [N*TW-1:0] lat_limit,
  output logic [N-1:0]    must_yield
);

  logic [N-1:0]  req_act;
  logic [N-1:0]  gnt_act;
  logic          win_v;
  logic [IW-1:0] win_idx;
  logic          bus_idle_w;
  logic          start_w;
  logic [IW-1:0] start_idx_w;
  logic [IW-1:0] last_idx_w;
  logic          hold_w;

  assign req_act = ~req_n;
  assign gnt_n   = ~gnt_act;

  cba_rr_select #(.N(N)) u_rr (
    .req      (req_act),
    .base_idx (last_idx_w),
    .win_v    (win_v),
    .win_idx  (win_idx)
  );

  cba_bus_watch #(.N(N), .TW(TW)) u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .gnt        (gnt_act),
    .lat_limit  (lat_limit),
    .bus_idle   (bus_idle_w),
    .start      (start_w),
    .start_idx  (start_idx_w),
    .last_idx   (last_idx_w),
    .must_yield (must_yield)
  );

  cba_grant_fsm #(.N(N)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_act),
    .win_v      (win_v),
    .win_idx    (win_idx),
    .park_mode  (park_mode),
    .park_agent (park_agent),
    .last_idx   (last_idx_w),
    .start      (start_w),
    .start_idx  (start_idx_w),
    .gnt        (gnt_act),
    .hold       (hold_w)
  );

endmodule

// File: rtl/cba_checker.sv
module cba_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic [N-1:0] gnt_n,
  input logic [1:0]   park_mode,
  input logic [N-1:0] must_yield,
  input logic         hold_w
);

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R2
  grant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~gnt_n != '0) |=> ((&gnt_n) || $stable(gnt_n)));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w |=> $stable(gnt_n));

  // R5
  park_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((park_mode == 2'd0 || park_mode == 2'd3) && (&req_n)) |=> (&gnt_n));

  // R10
  yield_ungranted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (must_yield & ~gnt_n) == '0);

  // R10
  yield_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(must_yield));

endmodule

bind central_bus_arbiter cba_checker #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_n      (req_n),
  .gnt_n      (gnt_n),
  .park_mode  (park_mode),
  .must_yield (must_yield),
  .hold_w     (hold_w)
);

// File: tb/tb_central_bus_arbiter.sv
`timescale 1ns/1ps
module tb_central_bus_arbiter;

  localparam int N     = 4;
  localparam int TW    = 8;
  localparam int IW    = 2;
  localparam int BOUND = 16 * N;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_nb = '1;
  logic [N-1:0]    gnt_n;
  logic            frame_nb = 1'b1;
  logic            irdy_nb = 1'b1;
  logic [1:0]      park_mode_b = 2'd0;
  logic [IW-1:0]   park_agent_b = '0;
  logic [N*TW-1:0] lat_b = '0;
  logic [N-1:0]    must_yield;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  central_bus_arbiter #(.N(N), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_nb), .gnt_n(gnt_n),
    .frame_n(frame_nb), .irdy_n(irdy_nb), .park_mode(park_mode_b),
    .park_agent(park_agent_b), .lat_limit(lat_b), .must_yield(must_yield)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: grant holder, unused flag, last owner, pending candidate, owner, tenure.
  int    m_gnt = -1, m_last = N - 1, m_cand = -1, m_owner = -1, m_tmr = 0;
  bit    m_used = 0;
  string m_tag = "R8";

  always @(posedge clk) begin
    if (rst_n) begin
      int tgt, ng, win;
      bit any, hold, idle, st;
      string tag;
      any = 0; win = -1;
      for (int k = 1; k <= N; k++) begin
        int p;
        p = (m_last + k) % N;
        if (!req_nb[p]) begin any = 1; if (win < 0) win = p; end
      end
      hold = (m_gnt >= 0) && !req_nb[m_gnt] && !m_used;
      if (hold)        begin tgt = m_gnt; tag = "R4"; end
      else if (any)    begin tgt = win;   tag = "R3"; end
      else if (park_mode_b == 2'd1) begin tgt = (int'(park_agent_b) < N) ? int'(park_agent_b) : -1; tag = "R6"; end
      else if (park_mode_b == 2'd2) begin tgt = m_last; tag = "R7"; end
      else             begin tgt = -1; tag = "R5"; end
      if (m_gnt < 0)          ng = tgt;
      else if (tgt == m_gnt)  ng = m_gnt;
      else                    begin ng = -1; tag = "R2"; end
      idle = frame_nb && irdy_nb;
      st   = (m_cand >= 0) && !frame_nb;
      if (ng != m_gnt) m_used = 0;
      else if (st && m_cand == m_gnt) m_used = 1;
      if (st) begin m_owner = m_cand; m_last = m_cand; m_tmr = 0; end
      else if (idle) begin m_owner = -1; m_tmr = 0; end
      else if (m_owner >= 0 && m_tmr < 255) m_tmr++;
      m_cand = (idle && m_gnt >= 0) ? m_gnt : -1;
      m_gnt  = ng;
      m_tag  = tag;
    end
  end

  // Bench masters and bus activity
  bit [N-1:0] want = '0;
  int wait_cnt[N];
  int go = -1, beats = 0, hidden_cnt = 0, yield_cnt = 0;
  logic [N-1:0] prev_gnt_n = '1;

  task automatic compare_outputs();
    logic [N-1:0] exp_g, exp_y;
    exp_g = '1;
    if (m_gnt >= 0) exp_g[m_gnt] = 1'b0;
    exp_y = '0;
    if (m_owner >= 0 && m_gnt != m_owner && !(frame_nb && irdy_nb) &&
        m_tmr >= int'(lat_b[m_owner*TW +: TW])) exp_y[m_owner] = 1'b1;
    chk(gnt_n == exp_g, m_tag, int'(gnt_n), int'(exp_g));
    chk(must_yield == exp_y, "R10", int'(must_yield), int'(exp_y));
    chk($onehot0(~gnt_n), "R1", int'(gnt_n), 0);
    chk((&prev_gnt_n) || (&gnt_n) || (gnt_n == prev_gnt_n), "R2", int'(gnt_n), int'(prev_gnt_n));
    if (gnt_n != prev_gnt_n && !(frame_nb && irdy_nb)) hidden_cnt++;
    if (|must_yield) yield_cnt++;
    prev_gnt_n = gnt_n;
  endtask

  task automatic step(input int rate);
    @(negedge clk);
    compare_outputs();
    for (int i = 0; i < N; i++) begin
      if (want[i]) wait_cnt[i]++;
      else if (rate > 0 && $urandom_range(rate - 1) == 0) begin want[i] = 1; wait_cnt[i] = 0; end
    end
    if (beats > 0) begin
      irdy_nb = 1'b0; frame_nb = (beats == 1); beats--;
    end else if (!(frame_nb && irdy_nb)) begin
      frame_nb = 1'b1; irdy_nb = 1'b1;
    end else if (go >= 0) begin
      // R11: wait from request to start is bounded
      chk(wait_cnt[go] <= BOUND, "R11", wait_cnt[go], BOUND);
      want[go] = 0;
      frame_nb = 1'b0; irdy_nb = 1'b1;
      beats = $urandom_range(5, 1);
      go = -1;
    end else begin
      for (int i = 0; i < N; i++) if (!gnt_n[i] && want[i]) go = i;
    end
    req_nb = ~want;
  endtask

  initial begin
    for (int i = 0; i < N; i++) wait_cnt[i] = 0;
    repeat (4) begin
      @(negedge clk);
      chk(&gnt_n, "R8", int'(gnt_n), int'({N{1'b1}}));
      chk(must_yield == '0, "R8", int'(must_yield), 0);
    end
    want = '1; req_nb = '0;
    rst_n = 1'b1;
    @(negedge clk);
    // R8 / R3: first search after reset begins at index 0
    chk(gnt_n == 4'b1110, "R8", int'(gnt_n), 'he);
    prev_gnt_n = gnt_n;
    for (int ph = 0; ph < 9; ph++) begin
      park_mode_b  = 2'(ph % 4);
      park_agent_b = IW'($urandom_range(N - 1));
      for (int i = 0; i < N; i++) lat_b[i*TW +: TW] = TW'($urandom_range(3));
      for (int c = 0; c < 2500; c++) step((ph % 3 == 0) ? 3 : 12);
      for (int c = 0; c < 150; c++) step(0);
    end
    for (int i = 0; i < N; i++)
      chk(!want[i], "R11", wait_cnt[i], BOUND);
    // R9: grants moved while a transaction was running
    chk(hidden_cnt > 0, "R9", hidden_cnt, 1);
    chk(yield_cnt > 0, "R10", yield_cnt, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule